// File: doc/BRIEF.md
# Block Read Return Controller

This controller sits on the memory side of a synchronous processor bus. The processor multiplexes addresses and data on one 64-bit bus and sends a 9-bit command beside it. The controller loads the address bus into its address register on every clock while it is idle. In the cycle where the processor's valid_out is high with a read command, the register freezes on that address. The controller then waits until the processor releases the bus and until the external write buffer is empty. After that it returns one doubleword or a whole block of doublewords. Each beat is preceded by a programmable number of wait states. Each beat is qualified by a one-cycle valid_in and tagged with a data identifier on the command bus.

Within a block the doubleword order follows one of two rules. In sub-block order the index of beat n is the start index XOR n. In sequential order the index advances from the start index and wraps inside the block. A memory error on a beat is flagged in that beat's identifier, and the block still runs to its end-of-data beat. The read-ready output is high only when a new read can be taken.

States and transitions:
- ST_IDLE tracks the bus. It goes to ST_DRAIN on an accepted read that has release in the same cycle, and to ST_RELW on an accepted read without it.
- ST_RELW waits for release, then goes to ST_DRAIN.
- ST_DRAIN waits for an empty write buffer. It then goes to ST_WAIT, or straight to ST_BEAT when the wait count is zero.
- ST_WAIT counts the wait states down, then goes to ST_BEAT.
- ST_BEAT drives one beat. It returns to ST_IDLE after the last beat. Otherwise it goes to ST_WAIT, or stays in ST_BEAT when the wait count is zero.

Top module: `blk_rd_return`

## Requirements
- R1: A read is accepted only when valid_out is high, command bit 8 is 0, bits 7:5 are 0, and bits 4:3 are 2 (block) or 3 (doubleword or smaller). Any other command with valid_out, including write requests and data identifiers, produces no valid_in, no ad_oe, and leaves rd_rdy high.
- R2: The doubleword addresses of the transaction come from bits 35:0 of the bus value in the accepting cycle. Bus values in later cycles and bus bits 63:36 have no effect.
- R3: ad_oe is low up to and including the cycle in which release is first seen. It is high from the next cycle through the last beat. Release may come with the command or any number of cycles after it.
- R4: No beat is returned while wbuf_empty is low. The first beat comes wait_cfg+1 cycles after the first cycle, from the cycle after release was seen on, in which wbuf_empty is high.
- R5: valid_in is high for exactly one cycle per beat, and wait_cfg idle cycles (0 to 15) separate consecutive beats.
- R6: A doubleword-or-smaller read returns 1 beat. A block read returns 2, 4, 8 or 16 beats for command bits 1:0 equal to 0, 1, 2 or 3 (4, 8, 16 or 32 words).
- R7: Address bits 3 and up select the doubleword, and the start index s is taken from the low log2(beats) of them. With seq_mode=0, beat n uses index s XOR n. With seq_mode=1, it uses (s+n) mod beats. Higher address bits stay as captured, and bits 2:0 of mem_addr are 0.
- R8: Beat identifiers are built as follows. Bit 8 is 1. Bit 7 is 1 for a non-last beat and 0 for the last. Bit 6 is 0 (response data). Bit 5 equals mem_err for that beat. Bit 4 equals chk_off. Bit 3 is 0 and bits 2:0 are 3'b100. So the identifiers are 9'b110000100 for a non-last beat and 9'b100000100 for the last.
- R9: A beat with mem_err high carries bit 5 set. The remaining beats of the block are still returned, ending with a last-beat identifier.
- R10: rd_rdy is high only while the controller is idle and wbuf_empty is high. It is low from the cycle after acceptance through the last beat.
- R11: After reset the controller is idle: valid_in and ad_oe are low, and rd_rdy follows wbuf_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ad_in | input | 64 | Address/data bus as driven by the processor |
| bus_cmd_in | input | 9 | Command bus as driven by the processor |
| valid_out | input | 1 | Processor drives a valid command |
| release_in | input | 1 | Processor releases the bus after this cycle |
| wbuf_empty | input | 1 | External write buffer holds no pending writes |
| seq_mode | input | 1 | 1: sequential wrap order, 0: sub-block XOR order |
| wait_cfg | input | 4 | Wait states before each beat |
| chk_off | input | 1 | Set the check-disable bit in identifiers |
| mem_rdata | input | 64 | Read data from memory at mem_addr |
| mem_err | input | 1 | Memory reports an error for mem_addr |
| mem_addr | output | 36 | Doubleword address of the current beat |
| bus_ad_out | output | 64 | Returned read data |
| bus_cmd_out | output | 9 | Data identifier |
| valid_in | output | 1 | Controller drives a valid beat |
| ad_oe | output | 1 | Controller owns the bus |
| rd_rdy | output | 1 | Controller can accept a read |

## Verification
Two functions can fall in the same cycle: the address freeze and the release, when release arrives with the read command. Likewise, the end of the write-buffer drain can coincide with the cycle right after release. The bench provokes both by placing release in the command cycle, or by letting the write buffer go empty before release is seen. It then judges whether ad_oe rises exactly one cycle after release and whether the first beat lands wait_cfg+1 cycles after the later of the two conditions. The bench also moves the bus to unrelated values after acceptance, so any late reload of the address shows up as wrong mem_addr and wrong data.

// File: rtl/blk_rd_pkg.sv
package blk_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELW,
        ST_DRAIN,
        ST_WAIT,
        ST_BEAT
    } rd_state_t;

    localparam logic [2:0] ID_STATE_BITS = 3'b100;
endpackage

// File: rtl/blk_rd_cmd_dec.sv
module blk_rd_cmd_dec #(
    parameter int CMD_W = 9,
    parameter int LG_W  = 3
) (
    input  logic [CMD_W-1:0] cmd,
    output logic             is_read,
    output logic [LG_W-1:0]  beats_lg
);
    logic is_block;
    logic is_single;

    always_comb begin
        is_block  = (cmd[4:3] == 2'b10);
        is_single = (cmd[4:3] == 2'b11);
        is_read   = !cmd[CMD_W-1] && (cmd[7:5] == 3'd0) && (is_block || is_single);
        beats_lg  = is_single ? '0 : (LG_W'(cmd[1:0]) + LG_W'(1));
    end
endmodule

// File: rtl/blk_rd_order.sv
module blk_rd_order #(
    parameter int IDX_W     = 4,
    parameter int LG_W      = 3,
    parameter bit ALLOW_SEQ = 1'b1
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] beat_n,
    input  logic [LG_W-1:0]  beats_lg,
    input  logic             seq_mode,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] xor_idx;
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        mask    = ~({IDX_W{1'b1}} << beats_lg);
        xor_idx = start_idx ^ beat_n;
    end

    generate
        if (ALLOW_SEQ) begin : g_seq
            logic [IDX_W-1:0] add_idx;
            always_comb begin
                add_idx = start_idx + beat_n;
                sel_idx = seq_mode ? add_idx : xor_idx;
            end
        end else begin : g_xor_only
            always_comb sel_idx = xor_idx;
        end
    endgenerate

    always_comb idx = (start_idx & ~mask) | (sel_idx & mask);
endmodule

// File: rtl/blk_rd_waitcnt.sv
module blk_rd_waitcnt #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              done
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - WAIT_W'(1);
    end

    always_comb done = (cnt_q == '0);

    // R5
    wait_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - WAIT_W'(1)));
endmodule

// File: rtl/blk_rd_return.sv
module blk_rd_return
    import blk_rd_pkg::*;
#(
    parameter int BUS_W  = 64,
    parameter int CMD_W  = 9,
    parameter int ADDR_W = 36,
    parameter int WAIT_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_ad_in,
    input  logic [CMD_W-1:0]  bus_cmd_in,
    input  logic              valid_out,
    input  logic              release_in,
    input  logic              wbuf_empty,
    input  logic              seq_mode,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              chk_off,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic              mem_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  bus_ad_out,
    output logic [CMD_W-1:0]  bus_cmd_out,
    output logic              valid_in,
    output logic              ad_oe,
    output logic              rd_rdy
);
    localparam int DW_LSB = 3;
    localparam int LG_W   = $clog2(IDX_W + 1);

    rd_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LG_W-1:0]   lg_q;
    logic [IDX_W-1:0]  beat_q;
    logic              dec_read;
    logic [LG_W-1:0]   dec_lg;
    logic              accept;
    logic              last_beat;
    logic [IDX_W-1:0]  cur_idx;
    logic              wt_load;
    logic              wt_done;
    logic [WAIT_W-1:0] wt_val;

    blk_rd_cmd_dec #(.CMD_W(CMD_W), .LG_W(LG_W)) u_dec (
        .cmd      (bus_cmd_in),
        .is_read  (dec_read),
        .beats_lg (dec_lg)
    );

    blk_rd_order #(.IDX_W(IDX_W), .LG_W(LG_W), .ALLOW_SEQ(1'b1)) u_ord (
        .start_idx (addr_q[DW_LSB +: IDX_W]),
        .beat_n    (beat_q),
        .beats_lg  (lg_q),
        .seq_mode  (seq_mode),
        .idx       (cur_idx)
    );

    blk_rd_waitcnt #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wt_load),
        .load_val (wt_val),
        .done     (wt_done)
    );

    always_comb begin
        accept    = (state_q == ST_IDLE) && valid_out && dec_read;
        last_beat = (beat_q == ~({IDX_W{1'b1}} << lg_q));
        wt_val    = wait_cfg - WAIT_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        wt_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = release_in ? ST_DRAIN : ST_RELW;
            end
            ST_RELW: begin
                if (release_in)
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wbuf_empty) begin
                    state_d = (wait_cfg == '0) ? ST_BEAT : ST_WAIT;
                    wt_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (wt_done)
                    state_d = ST_BEAT;
            end
            ST_BEAT: begin
                if (last_beat) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = (wait_cfg == '0) ? ST_BEAT : ST_WAIT;
                    wt_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transaction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            lg_q   <= '0;
            beat_q <= '0;
        end else begin
            if (state_q == ST_IDLE)
                addr_q <= bus_ad_in[ADDR_W-1:0];
            if (accept) begin
                lg_q   <= dec_lg;
                beat_q <= '0;
            end else if (state_q == ST_BEAT && !last_beat) begin
                beat_q <= beat_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        valid_in    = (state_q == ST_BEAT);
        ad_oe       = (state_q == ST_DRAIN) || (state_q == ST_WAIT) || (state_q == ST_BEAT);
        rd_rdy      = (state_q == ST_IDLE) && wbuf_empty;
        mem_addr    = {addr_q[ADDR_W-1:DW_LSB+IDX_W], cur_idx, {DW_LSB{1'b0}}};
        bus_ad_out  = valid_in ? mem_rdata : '0;
        bus_cmd_out = '0;
        if (valid_in)
            bus_cmd_out = {1'b1, !last_beat, 1'b0, mem_err, chk_off, 1'b0, ID_STATE_BITS};
    end

    // R3
    relw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELW && !release_in) |=> (state_q == ST_RELW && !ad_oe));
    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !wbuf_empty) |=> (state_q == ST_DRAIN && !valid_in));
    // R2
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(addr_q));
    // R10
    rdy_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !rd_rdy);
    // R6
    last_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !bus_cmd_out[7]) |=> (state_q == ST_IDLE));
endmodule

// File: tb/sim_blk_rd_return.sv
`timescale 1ns/1ps
module sim_blk_rd_return;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] bus_ad_in = '0;
    logic [8:0]  bus_cmd_in = '0;
    logic        valid_out = 1'b0;
    logic        release_in = 1'b0;
    logic        wbuf_empty = 1'b1;
    logic        seq_mode = 1'b0;
    logic [3:0]  wait_cfg = '0;
    logic        chk_off = 1'b0;
    logic [63:0] mem_rdata;
    logic        mem_err;
    logic [35:0] mem_addr;
    logic [63:0] bus_ad_out;
    logic [8:0]  bus_cmd_out;
    logic        valid_in, ad_oe, rd_rdy;

    logic        err_on = 1'b0;
    logic [3:0]  err_idx = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    blk_rd_return u0 (
        .clk(clk), .rst_n(rst_n), .bus_ad_in(bus_ad_in), .bus_cmd_in(bus_cmd_in),
        .valid_out(valid_out), .release_in(release_in), .wbuf_empty(wbuf_empty),
        .seq_mode(seq_mode), .wait_cfg(wait_cfg), .chk_off(chk_off),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .mem_addr(mem_addr),
        .bus_ad_out(bus_ad_out), .bus_cmd_out(bus_cmd_out), .valid_in(valid_in),
        .ad_oe(ad_oe), .rd_rdy(rd_rdy)
    );

    function automatic logic [63:0] mem_word(input logic [35:0] a);
        return {a[27:0] ^ 28'h5A5A5A5, a};
    endfunction

    always_comb begin
        mem_rdata = mem_word(mem_addr);
        mem_err   = err_on && (mem_addr[6:3] == err_idx);
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: computes the cycle of every event from the stimulus plan.
    task automatic run_rd(input logic [63:0] a, input logic [8:0] c, input int rel, input int dly,
                          input int w, input bit sq, input bit ck, input bit eon, input int eidx);
        int nb, s, j, b0, last_t;
        nb = (c[4:3] == 2'b11) ? 1 : (2 << c[1:0]);
        s  = rel + 1;
        j  = (dly > s) ? dly : s;
        b0 = j + 1 + w;
        last_t = b0 + (nb - 1) * (w + 1);
        seq_mode = sq; chk_off = ck; wait_cfg = 4'(w);
        err_on = eon; err_idx = 4'(eidx);
        for (int t = 0; t <= last_t + 2; t++) begin
            @(posedge clk); #1;
            valid_out  = (t == 0);
            bus_cmd_in = (t == 0) ? c : 9'h1FF;
            bus_ad_in  = (t == 0) ? a : {$urandom, $urandom};
            release_in = (t == rel);
            wbuf_empty = (t >= dly);
            #1;
            begin
                bit exp_v, exp_oe, exp_rdy;
                exp_v   = (t >= b0) && (t <= last_t) && (((t - b0) % (w + 1)) == 0);
                exp_oe  = (t >= s) && (t <= last_t);
                exp_rdy = ((t == 0) || (t > last_t)) && (t >= dly);
                chk(valid_in == exp_v, "R5 valid_in per beat", 64'(valid_in), 64'(exp_v));
                chk(ad_oe == exp_oe, "R3 ad_oe after release", 64'(ad_oe), 64'(exp_oe));
                chk(rd_rdy == exp_rdy, "R10 rd_rdy", 64'(rd_rdy), 64'(exp_rdy));
                if (exp_v && valid_in) begin
                    int n, st, mk, ix;
                    logic [35:0] ea;
                    logic [8:0]  ec;
                    bit isl, eb;
                    n  = (t - b0) / (w + 1);
                    mk = nb - 1;
                    st = int'(a[6:3]);
                    ix = (st & ~mk & 15) | ((sq ? (st + n) : (st ^ n)) & mk);
                    ea = {a[35:7], 4'(ix), 3'b000};
                    isl = (n == nb - 1);
                    eb  = eon && (ix == eidx);
                    ec  = {1'b1, !isl, 1'b0, eb, ck, 1'b0, 3'b100};
                    chk(mem_addr == ea, "R7 beat order / R2 captured address", 64'(mem_addr), 64'(ea));
                    chk(bus_ad_out == mem_word(ea), "R2 returned data", bus_ad_out, mem_word(ea));
                    chk(bus_cmd_out == ec, "R8 R9 identifier", 64'(bus_cmd_out), 64'(ec));
                end
            end
        end
        valid_out = 1'b0; release_in = 1'b0; wbuf_empty = 1'b1; err_on = 1'b0;
    endtask

    task automatic run_ignored(input logic [8:0] c);
        for (int t = 0; t < 6; t++) begin
            @(posedge clk); #1;
            valid_out  = (t == 0);
            bus_cmd_in = c;
            bus_ad_in  = {$urandom, $urandom};
            release_in = 1'b1;
            #1;
            chk(!valid_in && !ad_oe, "R1 ignored command no beat", {62'd0, valid_in, ad_oe}, 64'd0);
            chk(rd_rdy, "R1 ignored command rd_rdy", 64'(rd_rdy), 64'd1);
        end
        valid_out = 1'b0; release_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        chk(!valid_in && !ad_oe, "R11 reset outputs idle", {62'd0, valid_in, ad_oe}, 64'd0);
        chk(rd_rdy == wbuf_empty, "R11 reset rd_rdy", 64'(rd_rdy), 64'(wbuf_empty));
        @(posedge clk); #1 rst_n = 1'b1;
        // R6 single doubleword, release with command
        run_rd(64'hFFFF_F001_2345_6718, 9'b000011011, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0);
        // R7 sub-block, 4 beats, late release, wait states
        run_rd(64'h0000_0009_8765_4328, 9'b000010001, 3, 0, 2, 1'b0, 1'b0, 1'b0, 0);
        // R4 drain longer than release wait, sequential, 8 beats
        run_rd(64'hABCD_0004_4444_0028, 9'b000010010, 0, 6, 1, 1'b1, 1'b0, 1'b0, 0);
        // R9 16 beats, error mid-block, check disabled
        run_rd(64'h1234_000F_0000_1058, 9'b000010011, 2, 1, 0, 1'b0, 1'b1, 1'b1, 4);
        // R6 2 beats sequential, maximum wait
        run_rd(64'h0000_0001_1111_1118, 9'b000010000, 1, 4, 15, 1'b1, 1'b0, 1'b0, 0);
        // R5 4 beats sequential start 3
        run_rd(64'h0000_0003_0303_0318, 9'b000010001, 0, 0, 0, 1'b1, 1'b0, 1'b1, 3);
        // R1 commands that must be ignored
        run_ignored(9'b001010001);
        run_ignored(9'b110000100);
        run_ignored(9'b000000001);
        run_rd(64'h0000_0000_0000_0010, 9'b000011111, 5, 2, 3, 1'b0, 1'b0, 1'b0, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule